// File: doc/BRIEF.md
# I2C Byte-Array Read Target

This block is a target on a two-wire serial bus that exposes a 256-byte array through a single internal byte pointer. The pointer serves both directions. After any byte is read or written it points at the following location, and it rolls from the top of the array back to location zero. A controller fetches data in three ways. It can read straight from the pointer. It can first send a write transfer that carries only a byte address and then, after a repeated START, read from that address. It can also keep clocking bytes out for as long as it acknowledges each one.

A write transfer loads the pointer from its first byte. Every later byte of the same transfer is stored at the pointer, and the pointer then steps on by one. The bus pins are open-drain. The block samples SCL and SDA on its own system clock through two-flop synchronisers, and it pulls SDA low through an output-enable. The target address is a fixed four-bit prefix followed by three strap bits.

Top module: `i2c_mem_target`

## Requirements
- R1: The target acknowledges only the 7-bit address made of 1010 followed by `strap_i[2:0]`, with the R/W bit last (1 = read). Any other address gets no acknowledge, and every byte after it is ignored until the next START or STOP. An ignored byte does not change the pointer.
- R2: A read that follows the address directly returns the byte at the pointer, most significant bit first. The pointer is always one past the last byte read or written.
- R3: A write of only a byte address, then a repeated START and a read address, returns the byte at that byte address.
- R4: An acknowledge from the controller after a data byte makes the target send the next byte. A not-acknowledge makes it release SDA and send nothing more until a STOP or START.
- R5: The pointer rolls from 255 to 0 on both reads and writes, and valid data continues after the roll.
- R6: In a write transfer the first byte after the address loads the pointer. Each later byte is stored at the pointer, which then advances by one. The target acknowledges every byte.
- R7: A repeated START at a byte boundary restarts address decoding, releases SDA and leaves the pointer unchanged.
- R8: The target changes SDA only while SCL is low. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.
- R9: After reset the target does not drive SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 3 | Low three bits of the target address |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest case to reach is the pointer rolling over in the middle of a transfer. The array must first hold known contents at every location, and the pointer must then be carried past 255 by both a write stream and a read stream. The bench writes a computed pattern to all 256 locations in one transfer, starting at zero, which leaves the pointer rolled back to zero. It then reads the whole array back in one sequential burst and runs a second burst that starts near the top, so the read path crosses the boundary as well. Every wrong strap value is tried as an address, and a byte follows each one to show that the ignored transfer cannot move the pointer.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
    localparam int PTR_W  = 8;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_t;

    typedef struct packed {
        tgt_state_t        st;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [PTR_W-1:0]  ptr;
        logic              rw;
        logic              first;
        logic              mack;
        logic              oe;
    } tgt_regs_t;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[s] <= '1;
            end else if (s == 0) begin
                chain_q[s] <= din;
            end else begin
                chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
    assign start_ev = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_ev  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe
);
    logic [1:0] bus_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_ev, stop_ev;
    logic [BYTE_W-1:0] rdata;
    logic       mem_we;
    logic       ptr_load;
    tgt_regs_t  q, d;

    i2c_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (bus_s)
    );
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    i2c_bus_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    i2c_mem_array #(.AW(PTR_W), .DW(BYTE_W)) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .waddr(q.ptr),
        .wdata(q.sh),
        .raddr(q.ptr),
        .rdata(rdata)
    );

    always_comb begin
        d        = q;
        mem_we   = 1'b0;
        ptr_load = 1'b0;
        if (stop_ev) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_ev) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall && q.cnt == CNT_W'(8)) begin
                        if (q.sh[7:1] == {DEV_PREFIX, strap_i}) begin
                            d.rw = q.sh[0];
                            d.oe = 1'b1;
                            d.st = ST_ADDR_ACK;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh  = rdata;
                            d.oe  = ~rdata[BYTE_W-1];
                            d.ptr = q.ptr + PTR_W'(1);
                            d.st  = ST_RD;
                        end else begin
                            d.oe    = 1'b0;
                            d.first = 1'b1;
                            d.st    = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall && q.cnt == CNT_W'(8)) begin
                        if (q.first) begin
                            d.ptr    = q.sh;
                            d.first  = 1'b0;
                            ptr_load = 1'b1;
                        end else begin
                            mem_we = 1'b1;
                            d.ptr  = q.ptr + PTR_W'(1);
                        end
                        d.cnt = '0;
                        d.oe  = 1'b1;
                        d.st  = ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (q.cnt == CNT_W'(8)) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.st  = ST_RD_ACK;
                        end else begin
                            d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.sh  = rdata;
                            d.oe  = ~rdata[BYTE_W-1];
                            d.ptr = q.ptr + PTR_W'(1);
                            d.st  = ST_RD;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, ptr: '0,
                   rw: 1'b0, first: 1'b0, mack: 1'b0, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scl_i,
    input logic         sda_oe,
    input logic         start_ev,
    input logic         stop_ev,
    input logic [W-1:0] ptr,
    input logic         ptr_load
);
    // R8: the data line only moves while the bus clock is low
    a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R9: released when reset ends
    a_r9_released_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_oe);

    // R7: a START hands the line back
    a_r7_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe);

    // R4: a STOP hands the line back
    a_r4_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R5: apart from a load, the pointer only steps by one modulo the depth
    a_r5_ptr_steps_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr != $past(ptr)) && !$past(ptr_load)) |-> (ptr == W'($past(ptr) + 1'b1)));
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.W(i2c_mem_pkg::PTR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .ptr     (q.ptr),
    .ptr_load(ptr_load)
);

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
    localparam int Q = 5;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic mlow = 1'b0;
    logic sda_line;
    logic sda_oe;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'd0;

    always #2.5 clk = ~clk;

    assign sda_line = ~(mlow | sda_oe);

    i2c_mem_target dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .strap_i(STRAP),
        .sda_oe (sda_oe)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic r);
        scl = 1'b0; tick();
        mlow = ~b;  tick();
        scl = 1'b1; tick();
        r = sda_line; tick();
    endtask

    task automatic bus_start();
        scl = 1'b0; tick();
        mlow = 1'b0; tick();
        scl = 1'b1; tick();
        mlow = 1'b1; tick();
    endtask

    task automatic bus_stop();
        scl = 1'b0; tick();
        mlow = 1'b1; tick();
        scl = 1'b1; tick();
        mlow = 1'b0; tick();
    endtask

    task automatic tx_byte(input logic [7:0] v, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(v[i], r);
        bit_io(1'b1, r);
        acked = ~r;
    endtask

    task automatic rx_byte(input logic ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            v[i] = r;
        end
        bit_io(~ack, r);
    endtask

    task automatic addr_phase(input logic [2:0] strap, input logic rw, output logic acked);
        tx_byte({4'b1010, strap, rw}, acked);
    endtask

    // read n bytes from the current pointer and compare against the model
    task automatic read_burst(input int n, input string req);
        logic [7:0] v;
        for (int k = 0; k < n; k++) begin
            rx_byte(k != n - 1, v);
            chk(req, v, exp_mem[exp_ptr], $sformatf("byte at %0h", exp_ptr));
            exp_ptr = exp_ptr + 8'd1;
        end
    endtask

    task automatic set_ptr_and_read(input logic [7:0] a, input int n, input string req);
        logic ak;
        bus_start();
        addr_phase(STRAP, 1'b0, ak); chk(req, ak, 1, "write address ack");
        tx_byte(a, ak);              chk(req, ak, 1, "byte address ack");
        exp_ptr = a;
        bus_start();
        addr_phase(STRAP, 1'b1, ak); chk(req, ak, 1, "read address ack");
        read_burst(n, req);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ak;
        logic r;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        // R9 reset state
        chk("R9", sda_oe, 0, "sda_oe after reset");
        chk("R9", sda_line, 1, "bus line after reset");

        // R6 and R5: fill the whole array from 0 in one transfer; the pointer rolls to 0
        bus_start();
        addr_phase(STRAP, 1'b0, ak); chk("R1", ak, 1, "matching write address ack");
        tx_byte(8'h00, ak);          chk("R6", ak, 1, "byte address ack");
        for (int i = 0; i < 256; i++) begin
            exp_mem[i] = pat(i);
            tx_byte(pat(i), ak);
            chk("R6", ak, 1, "data byte ack");
        end
        bus_stop();
        exp_ptr = 8'h00;

        // R2 and R5: a plain read after the rolled-over fill returns location 0
        bus_start();
        addr_phase(STRAP, 1'b1, ak); chk("R1", ak, 1, "matching read address ack");
        read_burst(1, "R2");
        // R4: after NACK the target sends nothing on further clocks
        bit_io(1'b1, r); chk("R4", r, 1, "line released after nack");
        bus_stop();

        // R3 and R4: read the whole array in one burst from 0
        set_ptr_and_read(8'h00, 256, "R4");
        // R5: the read burst crosses from 255 to 0
        set_ptr_and_read(8'hF0, 20, "R5");

        // R2: the pointer continues one past the last read byte
        bus_start();
        addr_phase(STRAP, 1'b1, ak);
        read_burst(1, "R2");
        bus_stop();

        // R1: every other strap value is ignored, including the byte after it
        for (int s = 0; s < 8; s++) begin
            if (3'(s) != STRAP) begin
                bus_start();
                addr_phase(3'(s), 1'b0, ak); chk("R1", ak, 0, $sformatf("no ack strap %0d", s));
                tx_byte(8'h77, ak);          chk("R1", ak, 0, "no ack on ignored byte");
                bus_stop();
            end
        end
        bus_start();
        addr_phase(3'(STRAP ^ 3'b010), 1'b1, ak); chk("R1", ak, 0, "no ack wrong read address");
        bus_stop();
        bus_start();
        addr_phase(STRAP, 1'b1, ak);
        read_burst(1, "R1");
        bus_stop();

        // R6: a short write, then read-back both ways
        bus_start();
        addr_phase(STRAP, 1'b0, ak);
        tx_byte(8'h40, ak);
        tx_byte(8'hA5, ak); chk("R6", ak, 1, "ack first data");
        tx_byte(8'h5A, ak); chk("R6", ak, 1, "ack second data");
        bus_stop();
        exp_mem[8'h40] = 8'hA5;
        exp_mem[8'h41] = 8'h5A;
        exp_ptr = 8'h42;
        bus_start();
        addr_phase(STRAP, 1'b1, ak);
        read_burst(1, "R6");
        bus_stop();
        set_ptr_and_read(8'h40, 2, "R6");

        // R5: a write that rolls the pointer through 255
        bus_start();
        addr_phase(STRAP, 1'b0, ak);
        tx_byte(8'hFF, ak);
        tx_byte(8'h3C, ak);
        tx_byte(8'hC3, ak);
        bus_stop();
        exp_mem[8'hFF] = 8'h3C;
        exp_mem[8'h00] = 8'hC3;
        set_ptr_and_read(8'hFF, 2, "R5");

        // R7: a repeated START with no byte address leaves the pointer alone
        bus_start();
        addr_phase(STRAP, 1'b0, ak); chk("R7", ak, 1, "write address ack");
        bus_start();
        addr_phase(STRAP, 1'b1, ak); chk("R7", ak, 1, "read address ack after restart");
        read_burst(1, "R7");
        bus_stop();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule